// File: doc/BRIEF.md
# Prescaled Periodic Down-Counting Timer

A single timer channel built around a 24-bit down-counter. An 8-bit prescaler in front of the counter produces one tick every P+1 clocks, where P is a field in the control word. The counter takes a new value from an initial-count register when counting is switched on. In periodic mode it reloads from that register each time a tick finds it at zero. In one-shot mode it stays at zero and switches itself off. Each expiry gives a one-clock pulse on `expire_o`.

Software reaches three 32-bit registers through a plain register bus made of address, write enable, write data and read data. Reads are combinational and writes take effect at the clock edge. Offset 0x00 is the control word. Bits 7:0 hold the prescale value P, bit 27 selects periodic mode and bit 30 enables counting. Offset 0x08 holds the 24-bit initial count. Offset 0x10 returns the live count and cannot be written. One clock drives the whole block.

Top module: `pscl_timer`

## Requirements
- R1: After reset all three registers read zero and `expire_o` is low.
- R2: A control write that sets bit 30 while the timer is stopped loads the count from the initial-count register at that edge. A control write that sets bit 30 while the timer is already running does not reload the count.
- R3: With P in control bits 7:0, the count decrements once every P+1 clocks. The first decrement comes P+1 clocks after the enabling edge.
- R4: In periodic mode (bit 27 = 1), a tick that finds the count at zero reloads the initial count and raises `expire_o` for exactly one clock.
- R5: In one-shot mode (bit 27 = 0), a tick that finds the count at zero leaves the count at zero, raises `expire_o` for one clock and clears control bit 30.
- R6: The control word reads back only bits 30, 27 and 7:0; all other bits read zero. Addresses other than 0x00, 0x08 and 0x10 read zero.
- R7: Offset 0x10 returns the live count in bits 23:0 with bits 31:24 zero, and writes to it have no effect.
- R8: A control write with bit 30 clear freezes the count and returns the prescaler to zero. A later enable therefore waits a full P+1 clocks before the first tick.
- R9: Offset 0x08 keeps the 24 bits written and reads them back. Writing it while the timer runs changes the count only at the next reload.
- R10: `expire_o` is raised only in the clock after a tick that found the count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| expire_o | output | 1 | One-clock pulse on each expiry |

## Verification
The one-shot assertion assumes that no control write lands in the same clock as a one-shot expiry, because a bus write takes priority over the hardware clearing bit 30. The decrement-step property assumes that the only way to move the count by more than one is a control write that starts the timer. Each directed task stops the timer with a zero control write before it sets up the next scenario, and it issues its writes only at known cycle counts relative to the enabling edge. This keeps the stimulus inside those assumptions.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int CNT_W    = 24;
  localparam int DIV_W    = 8;
  localparam int BIT_RUN  = 30;
  localparam int BIT_PER  = 27;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_INIT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h10;
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler #(
  parameter int DIV_W = pscl_timer_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] ps_q, ps_d;
  logic             wrap;

  assign wrap = (ps_q == div);
  assign tick = run && wrap;

  always_comb begin
    ps_d = ps_q;
    if (!run)      ps_d = '0;
    else if (wrap) ps_d = '0;
    else           ps_d = ps_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/pscl_downcount.sv
module pscl_downcount #(
  parameter int CNT_W = pscl_timer_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] init,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             at_zero, zero_tick, step;

  assign at_zero   = (cnt_q == '0);
  assign step      = run && tick && !load;
  assign zero_tick = step && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      cnt_d = init;
    end else if (step) begin
      if (at_zero) begin
        exp_d = 1'b1;
        if (periodic) cnt_d = init;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
  assign done_o   = zero_tick && !periodic;
endmodule

// File: rtl/pscl_regs.sv
module pscl_regs
  import pscl_timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int PW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] cnt_i,
  input  logic          done_i,
  output logic          run_o,
  output logic          per_o,
  output logic [PW-1:0] div_o,
  output logic [CW-1:0] init_o,
  output logic          start_o
);
  logic          run_q, run_d, per_q, per_d;
  logic [PW-1:0] div_q, div_d;
  logic [CW-1:0] init_q, init_d;
  logic          wr_ctrl, wr_init;

  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_init = bus_we && (bus_addr == OFS_INIT);
  assign start_o = wr_ctrl && bus_wdata[BIT_RUN] && !run_q;

  always_comb begin
    run_d  = run_q;
    per_d  = per_q;
    div_d  = div_q;
    init_d = init_q;
    if (wr_ctrl) begin
      run_d = bus_wdata[BIT_RUN];
      per_d = bus_wdata[BIT_PER];
      div_d = bus_wdata[PW-1:0];
    end else if (done_i) begin
      run_d = 1'b0;
    end
    if (wr_init) init_d = bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      per_q  <= 1'b0;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      run_q  <= run_d;
      per_q  <= per_d;
      div_q  <= div_d;
      init_q <= init_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[BIT_RUN] = run_q;
        bus_rdata[BIT_PER] = per_q;
        bus_rdata[PW-1:0]  = div_q;
      end
      OFS_INIT: bus_rdata[CW-1:0] = init_q;
      OFS_DATA: bus_rdata[CW-1:0] = cnt_i;
      default:  bus_rdata = '0;
    endcase
  end

  assign run_o  = run_q;
  assign per_o  = per_q;
  assign div_o  = div_q;
  assign init_o = init_q;
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              expire_o
);
  logic             run_q, periodic_q, start, tick, done;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] init, cnt_q;

  pscl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt_q),
    .done_i(done), .run_o(run_q), .per_o(periodic_q), .div_o(div),
    .init_o(init), .start_o(start)
  );

  pscl_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .div(div), .tick(tick)
  );

  pscl_downcount u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .load(start), .tick(tick),
    .periodic(periodic_q), .init(init), .cnt_o(cnt_q),
    .expire_o(expire_o), .done_o(done)
  );
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk
  import pscl_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              expire_o,
  input logic              run_q,
  input logic              periodic_q,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_q
);
  logic wr_ctrl;
  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);

  AST_EXPIRE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> ($past(cnt_q) == '0 && $past(tick))); // R10

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !$past(periodic_q) && !$past(wr_ctrl)) |-> (!run_q && cnt_q == '0)); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && periodic_q && tick && cnt_q == '0 && !wr_ctrl) |=> expire_o); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_ctrl) |=> $stable(cnt_q)); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !wr_ctrl) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1))); // R3

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> ((bus_rdata & ~32'h4800_00FF) == '0)); // R6

  AST_DATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_DATA) |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R7
endmodule

bind pscl_timer pscl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .expire_o(expire_o), .run_q(run_q),
  .periodic_q(periodic_q), .tick(tick), .cnt_q(cnt_q)
);

// File: tb/tb_pscl_timer.sv
module tb_pscl_timer;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        expire_o;
  int          n_chk;
  int          n_err;
  logic [31:0] rd;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_INIT = 5'h08;
  localparam logic [4:0] A_DATA = 5'h10;

  pscl_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire_o(expire_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #2; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rdreg(A_CTRL, rd); check("R1 ctrl", rd, 32'h0);
    rdreg(A_INIT, rd); check("R1 init", rd, 32'h0);
    rdreg(A_DATA, rd); check("R1 data", rd, 32'h0);
    check("R1 expire", {31'b0, expire_o}, 32'h0);
  endtask

  task automatic t_ctrl_mask;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rdreg(A_CTRL, rd); check("R6 ctrl mask", rd, 32'h4800_00FF);
    rdreg(5'h04, rd);  check("R6 unmapped", rd, 32'h0);
    wr(A_CTRL, 32'h0);
    rdreg(A_CTRL, rd); check("R6 ctrl zero", rd, 32'h0);
  endtask

  task automatic t_periodic;
    wr(A_INIT, 32'h0000_0003);
    wr(A_CTRL, 32'h4800_0001);
    rdreg(A_DATA, rd); check("R2 load", rd, 32'd3);
    cyc(1); rdreg(A_DATA, rd); check("R3 hold", rd, 32'd3);
    cyc(1); rdreg(A_DATA, rd); check("R3 dec", rd, 32'd2);
    cyc(5); rdreg(A_DATA, rd); check("R3 zero", rd, 32'd0);
    check("R10 no early expire", {31'b0, expire_o}, 32'h0);
    cyc(1); rdreg(A_DATA, rd); check("R4 reload", rd, 32'd3);
    check("R4 expire high", {31'b0, expire_o}, 32'h1);
    cyc(1); check("R4 expire one clock", {31'b0, expire_o}, 32'h0);
    cyc(1); rdreg(A_DATA, rd); check("R4 restart", rd, 32'd2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_prescale;
    wr(A_INIT, 32'h0000_0002);
    wr(A_CTRL, 32'h4800_0004);
    cyc(4); rdreg(A_DATA, rd); check("R3 P=4 hold", rd, 32'd2);
    cyc(1); rdreg(A_DATA, rd); check("R3 P=4 first", rd, 32'd1);
    cyc(5); rdreg(A_DATA, rd); check("R3 P=4 second", rd, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(A_INIT, 32'h0000_0002);
    wr(A_CTRL, 32'h4000_0000);
    cyc(2); rdreg(A_DATA, rd); check("R5 at zero", rd, 32'd0);
    check("R10 quiet", {31'b0, expire_o}, 32'h0);
    cyc(1); check("R5 expire", {31'b0, expire_o}, 32'h1);
    rdreg(A_CTRL, rd); check("R5 enable cleared", rd, 32'h0);
    cyc(1); check("R5 single pulse", {31'b0, expire_o}, 32'h0);
    cyc(5); rdreg(A_DATA, rd); check("R5 stays zero", rd, 32'd0);
    check("R5 no second pulse", {31'b0, expire_o}, 32'h0);
  endtask

  task automatic t_data_ro;
    wr(A_DATA, 32'h0012_3456);
    rdreg(A_DATA, rd); check("R7 write ignored", rd, 32'd0);
    wr(A_INIT, 32'h00FF_FFFF);
    wr(A_CTRL, 32'h4800_0000);
    cyc(2); rdreg(A_DATA, rd); check("R7 max count", rd, 32'h00FF_FFFD);
    wr(A_CTRL, 32'h0);
    rdreg(A_DATA, rd); check("R7 frozen max", rd, 32'h00FF_FFFC);
    wr(A_DATA, 32'hFFFF_FFFF);
    rdreg(A_DATA, rd); check("R7 write ignored live", rd, 32'h00FF_FFFC);
  endtask

  task automatic t_disable;
    wr(A_INIT, 32'd10);
    wr(A_CTRL, 32'h4800_0003);
    cyc(6); rdreg(A_DATA, rd); check("R3 P=3", rd, 32'd9);
    wr(A_CTRL, 32'h0);
    cyc(10); rdreg(A_DATA, rd); check("R8 frozen", rd, 32'd9);
    wr(A_CTRL, 32'h4800_0003);
    rdreg(A_DATA, rd); check("R2 reload", rd, 32'd10);
    cyc(3); rdreg(A_DATA, rd); check("R8 prescaler cleared", rd, 32'd10);
    cyc(1); rdreg(A_DATA, rd); check("R8 first tick", rd, 32'd9);
    wr(A_CTRL, 32'h4800_0003);
    rdreg(A_DATA, rd); check("R2 no reload", rd, 32'd9);
    cyc(3); rdreg(A_DATA, rd); check("R2 keeps counting", rd, 32'd8);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_init_live;
    wr(A_INIT, 32'd4);
    wr(A_CTRL, 32'h4800_0000);
    wr(A_INIT, 32'hAB00_0001);
    rdreg(A_INIT, rd); check("R9 readback", rd, 32'h0000_0001);
    rdreg(A_DATA, rd); check("R9 count unaffected", rd, 32'd3);
    cyc(3); rdreg(A_DATA, rd); check("R9 reaches zero", rd, 32'd0);
    cyc(1); rdreg(A_DATA, rd); check("R9 new reload", rd, 32'd1);
    check("R4 expire on reload", {31'b0, expire_o}, 32'h1);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #1500000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_ctrl_mask();
    t_periodic();
    t_prescale();
    t_oneshot();
    t_data_ro();
    t_disable();
    t_init_live();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule